// File: doc/BRIEF.md
# Strapped-Address I2C Control Register Slave

This block is an I2C target that runs entirely in the system clock domain. It samples the bus clock and data lines through a short synchronizer and finds start and stop conditions in the sampled levels. It answers one 7-bit address. The upper six address bits are fixed by a parameter (default `001000`). The lowest bit follows a strap input, so a board can pick one of two addresses when another device shares the bus.

The block has no sub-address byte. After a write address, the data bytes go into a fixed chain of four 8-bit control registers, one byte per register, in chain order. After a read address, the same registers are shifted back out in the same order. Every register is always visible on a parallel output bus, so nearby logic can use the settings directly. The data line is only ever pulled low (open drain), and the block never holds the clock low to stretch it.

Top module: `i2c_chain_slave`

## Requirements
- R1: After reset all four registers read 0x00 and the block releases SDA (`sda_pull_low` = 0).
- R2: The block acknowledges an address byte whose first seven bits, MSB first, are `0,0,1,0,0,0,addr_strap`. The eighth bit selects the direction: 0 = write, 1 = read. The acknowledge is SDA held low during the ninth SCL pulse.
- R3: On an address mismatch the block leaves SDA released. It does not acknowledge later bytes and changes no register until the next start condition.
- R4: Written data bytes are taken MSB first. The k-th byte after the address goes to register k (k = 0..3, in the order interrupt control, block-detect control, filter control, test), which appears on `ctl_regs[8k+7:8k]`.
- R5: Every data byte written to a matched address is acknowledged on its ninth clock.
- R6: Bytes written after the fourth register are acknowledged, and no register changes.
- R7: A start, a repeated start or a stop returns the chain pointer to register 0.
- R8: A read returns the registers in chain order, MSB first, with SDA driven low for 0 bits. Bytes requested past the fourth register read as 0xFF.
- R9: After the master leaves the acknowledge bit of a read byte high (NACK), the block releases SDA until the next start or stop.
- R10: The block changes `sda_pull_low` only while the sampled SCL is low.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both judged on synchronized samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level as seen on the wire |
| sda_in | input | 1 | Bus data level as seen on the wire |
| addr_strap | input | 1 | Lowest bit of the target address |
| sda_pull_low | output | 1 | 1 pulls SDA low; 0 releases it |
| ctl_regs | output | 32 | Register k on bits [8k+7:8k] |

## Verification
Two events can coincide inside the engine. One is a start or stop condition, which resets the chain pointer. The other is a byte-boundary SCL edge, which advances the pointer or launches the next read byte. The bench provokes both: it issues a repeated start right after a write byte's acknowledge, and a stop right after a read NACK. It then judges the result by which register the next write lands in and by what the next read returns. A scoreboard pairs every acknowledge bit and read byte the bus master observes with the value the requirements predict.

// File: rtl/ics_pkg.sv
package ics_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_END,
        S_ADDR_ACK,
        S_WR,
        S_WR_END,
        S_WR_ACK,
        S_RD,
        S_RD_ACK,
        S_IGNORE
    } eng_state_t;

    // Sampled bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [6:0] rx,
                                      input logic [5:0] hi,
                                      input logic       strap);
        return rx == {hi, strap};
    endfunction

endpackage

// File: rtl/ics_line_sync.sv
module ics_line_sync
    import ics_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    // index SYNC_STAGES-1 is the synchronized level, index SYNC_STAGES the previous one
    logic [SYNC_STAGES:0] scl_sr;
    logic [SYNC_STAGES:0] sda_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_in};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_sr[SYNC_STAGES-1];
    assign scl_old = scl_sr[SYNC_STAGES];
    assign sda_now = sda_sr[SYNC_STAGES-1];
    assign sda_old = sda_sr[SYNC_STAGES];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/ics_reg_bank.sv
module ics_reg_bank
    import ics_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  wr_req_t                    wr,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [NUM_REGS-1:0][BYTE_W-1:0] reg_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q[g] <= '0;
            end else if (wr.en && wr_idx == IDX_W'(g)) begin
                reg_q[g] <= wr.data;
            end
        end
        assign regs_flat[g*BYTE_W +: BYTE_W] = reg_q[g];
    end

    // Past the end of the chain the line stays released: all ones
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = reg_q[i];
        end
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> wr_idx < IDX_W'(NUM_REGS)); // R6
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr.en |=> $stable(regs_flat)); // R4

endmodule

// File: rtl/ics_bit_engine.sv
module ics_bit_engine
    import ics_pkg::*;
#(
    parameter int          NUM_REGS = 4,
    parameter logic [5:0]  ADDR_HI  = 6'b001000,
    localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [IDX_W-1:0]  ptr,
    output wr_req_t           wr,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              sda_low
);
    localparam logic [IDX_W-1:0]  END_IDX  = IDX_W'(NUM_REGS);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
    localparam logic [BIT_CW-1:0] ALL_BITS = BIT_CW'(BYTE_W);

    eng_state_t        state;
    logic [BIT_CW-1:0] bcnt;
    logic [BYTE_W-1:0] rxsh;
    logic [BYTE_W-1:0] txsh;
    logic              rw;
    logic              nack;

    logic [IDX_W-1:0]  ptr_next;
    assign ptr_next = (ptr == END_IDX) ? ptr : ptr + 1'b1;

    always_ff @(posedge clk) begin
        wr.en <= 1'b0;
        if (rst) begin
            state   <= S_IDLE;
            ptr     <= '0;
            bcnt    <= '0;
            rxsh    <= '0;
            txsh    <= '0;
            rw      <= 1'b0;
            nack    <= 1'b0;
            sda_low <= 1'b0;
            wr.data <= '0;
            wr_idx  <= '0;
        end else if (ev.start) begin
            state   <= S_ADDR;
            ptr     <= '0;
            bcnt    <= '0;
            sda_low <= 1'b0;
        end else if (ev.stop) begin
            state   <= S_IDLE;
            ptr     <= '0;
            sda_low <= 1'b0;
        end else begin
            unique case (state)
                S_ADDR, S_WR: if (ev.scl_rise) begin
                    rxsh <= {rxsh[BYTE_W-2:0], ev.sda};
                    if (bcnt == LAST_BIT) state <= (state == S_ADDR) ? S_ADDR_END : S_WR_END;
                    else                  bcnt  <= bcnt + 1'b1;
                end
                S_ADDR_END: if (ev.scl_fall) begin
                    if (addr_hit(rxsh[BYTE_W-1:1], ADDR_HI, strap)) begin
                        sda_low <= 1'b1;
                        rw      <= rxsh[0];
                        state   <= S_ADDR_ACK;
                    end else begin
                        state   <= S_IGNORE;
                    end
                end
                S_WR_END: if (ev.scl_fall) begin
                    sda_low <= 1'b1;
                    wr.data <= rxsh;
                    wr_idx  <= ptr;
                    if (ptr != END_IDX) wr.en <= 1'b1;
                    ptr     <= ptr_next;
                    state   <= S_WR_ACK;
                end
                S_ADDR_ACK, S_WR_ACK: if (ev.scl_fall) begin
                    bcnt <= '0;
                    if (state == S_ADDR_ACK && rw) begin
                        txsh    <= rd_data;
                        sda_low <= ~rd_data[BYTE_W-1];
                        ptr     <= ptr_next;
                        state   <= S_RD;
                    end else begin
                        sda_low <= 1'b0;
                        state   <= S_WR;
                    end
                end
                S_RD: begin
                    if (ev.scl_rise) bcnt <= bcnt + 1'b1;
                    if (ev.scl_fall) begin
                        if (bcnt == ALL_BITS) begin
                            sda_low <= 1'b0;
                            state   <= S_RD_ACK;
                        end else begin
                            txsh    <= {txsh[BYTE_W-2:0], 1'b1};
                            sda_low <= ~txsh[BYTE_W-2];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (ev.scl_rise) nack <= ev.sda;
                    if (ev.scl_fall) begin
                        bcnt <= '0;
                        if (nack) begin
                            state <= S_IGNORE;
                        end else begin
                            txsh    <= rd_data;
                            sda_low <= ~rd_data[BYTE_W-1];
                            ptr     <= ptr_next;
                            state   <= S_RD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> !ev.scl); // R10
    AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == S_ADDR && ptr == '0 && !sda_low)); // R7
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == S_IDLE && ptr == '0 && !sda_low)); // R7
    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        state == S_IGNORE |-> (!sda_low && !wr.en)); // R3

endmodule

// File: rtl/i2c_chain_slave.sv
module i2c_chain_slave
    import ics_pkg::*;
#(
    parameter int         NUM_REGS    = 4,
    parameter logic [5:0] ADDR_HI     = 6'b001000,
    parameter int         SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic                       addr_strap,
    output logic                       sda_pull_low,
    output logic [NUM_REGS*BYTE_W-1:0] ctl_regs
);
    line_ev_t          ev;
    wr_req_t           wr;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;

    ics_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    ics_bit_engine #(.NUM_REGS(NUM_REGS), .ADDR_HI(ADDR_HI)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (addr_strap),
        .rd_data (rd_data),
        .ptr     (ptr),
        .wr      (wr),
        .wr_idx  (wr_idx),
        .sda_low (sda_pull_low)
    );

    ics_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .wr_idx    (wr_idx),
        .rd_idx    (ptr),
        .rd_data   (rd_data),
        .regs_flat (ctl_regs)
    );

endmodule

// File: tb/sim_i2c_chain_slave.sv
`timescale 1ns/1ps
module sim_i2c_chain_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_low;
    logic sda_line;
    logic [31:0] regs;
    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } item_t;
    item_t      expq[$];
    logic [7:0] obsq[$];

    assign sda_line = sda_m & ~sda_low;

    always #2 clk = ~clk;

    i2c_chain_slave u0 (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl),
        .sda_in       (sda_line),
        .addr_strap   (strap),
        .sda_pull_low (sda_low),
        .ctl_regs     (regs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        waitc(Q); sda_m = b;
        waitc(Q); scl = 1'b1;
        waitc(Q); r = sda_line;
        waitc(Q); scl = 1'b0;
    endtask

    task automatic start_c();
        sda_m = 1'b1; waitc(Q);
        scl = 1'b1;   waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl = 1'b0;
    endtask

    task automatic stop_c();
        waitc(Q); sda_m = 1'b0;
        waitc(Q); scl = 1'b1;
        waitc(Q); sda_m = 1'b1;
        waitc(Q);
    endtask

    // driver: pushes the predicted acknowledge level, then clocks the byte
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic r;
        expq.push_back('{val: {7'b0, exp_ack}, tag: tag});
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        obsq.push_back({7'b0, r});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic give_nack, input string tag);
        logic [7:0] got;
        logic r;
        expq.push_back('{val: exp, tag: tag});
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            got[i] = r;
        end
        bus_bit(give_nack, r);
        obsq.push_back(got);
    endtask

    function automatic logic [7:0] reg_k(input int k);
        return regs[8*k +: 8];
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // monitor: compares observed bus results with the predictions in order
    initial begin
        forever begin
            @(negedge clk);
            while (obsq.size() > 0 && expq.size() > 0) begin
                item_t e;
                logic [7:0] o;
                e = expq.pop_front();
                o = obsq.pop_front();
                check(e.tag, {24'b0, o}, {24'b0, e.val});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        waitc(5);
        rst = 1'b0;
        waitc(5);
        // R1: reset state
        check("R1 regs after reset", regs, 32'h0);
        check("R1 sda released", {31'b0, sda_low}, 32'h0);

        // R2 R4 R5: plain write of four registers, strap low -> address 0x20
        start_c();
        send_byte(8'h20, 1'b0, "R2 write address ack");
        send_byte(8'hA1, 1'b0, "R5 data ack 0");
        send_byte(8'hB2, 1'b0, "R5 data ack 1");
        send_byte(8'hC3, 1'b0, "R5 data ack 2");
        send_byte(8'hD4, 1'b0, "R5 data ack 3");
        stop_c();
        check("R4 reg0", {24'b0, reg_k(0)}, 32'hA1);
        check("R4 reg1", {24'b0, reg_k(1)}, 32'hB2);
        check("R4 reg2", {24'b0, reg_k(2)}, 32'hC3);
        check("R4 reg3", {24'b0, reg_k(3)}, 32'hD4);

        // R6: overflow bytes acked and dropped
        start_c();
        send_byte(8'h20, 1'b0, "R2 address ack");
        send_byte(8'h11, 1'b0, "R5 ack");
        send_byte(8'h22, 1'b0, "R5 ack");
        send_byte(8'h33, 1'b0, "R5 ack");
        send_byte(8'h44, 1'b0, "R5 ack");
        send_byte(8'h55, 1'b0, "R6 overflow ack");
        send_byte(8'h66, 1'b0, "R6 overflow ack");
        stop_c();
        check("R6 regs after overflow", regs, 32'h44332211);

        // R7: repeated start right after a data ack restarts the chain
        start_c();
        send_byte(8'h20, 1'b0, "R2 address ack");
        send_byte(8'h5A, 1'b0, "R5 ack");
        send_byte(8'h6B, 1'b0, "R5 ack");
        start_c();
        send_byte(8'h20, 1'b0, "R7 address ack after restart");
        send_byte(8'h77, 1'b0, "R7 ack");
        stop_c();
        check("R7 restart rewrites reg0", regs, 32'h44336B77);

        // R3: mismatched address 0010001 with strap low
        start_c();
        send_byte(8'h22, 1'b1, "R3 no address ack");
        send_byte(8'h99, 1'b1, "R3 no data ack");
        stop_c();
        check("R3 regs unchanged", regs, 32'h44336B77);

        // R8 R9: read whole chain, one past the end, NACK, then silence
        start_c();
        send_byte(8'h21, 1'b0, "R2 read address ack");
        recv_byte(8'h77, 1'b0, "R8 read reg0");
        recv_byte(8'h6B, 1'b0, "R8 read reg1");
        recv_byte(8'h33, 1'b0, "R8 read reg2");
        recv_byte(8'h44, 1'b0, "R8 read reg3");
        recv_byte(8'hFF, 1'b1, "R8 read past end");
        recv_byte(8'hFF, 1'b1, "R9 silent after nack");
        stop_c();

        // R7: stop right after a NACK, next read starts at reg0
        start_c();
        send_byte(8'h21, 1'b0, "R2 read address ack");
        recv_byte(8'h77, 1'b0, "R8 read reg0");
        recv_byte(8'h6B, 1'b1, "R8 read reg1 nack");
        stop_c();
        start_c();
        send_byte(8'h21, 1'b0, "R2 read address ack");
        recv_byte(8'h77, 1'b1, "R7 read restarts at reg0");
        stop_c();

        // R2 R3: strap high moves the address to 0010001
        strap = 1'b1;
        start_c();
        send_byte(8'h20, 1'b1, "R3 old address ignored");
        stop_c();
        start_c();
        send_byte(8'h22, 1'b0, "R2 strap address ack");
        send_byte(8'hEE, 1'b0, "R5 ack");
        stop_c();
        check("R2 write via strap address", regs, 32'h44336BEE);
        check("R11 sda released at idle", {31'b0, sda_low}, 32'h0);

        waitc(20);
        check("R8 scoreboard drained", expq.size(), 32'h0);
        summary();
    end

endmodule